// File: doc/BRIEF.md
# MII Receive Nibble-to-Byte Assembler

This block sits on the MAC side of a media independent interface and runs in the receive clock domain. Each rising edge it samples a 4-bit data nibble together with the receive data valid, receive error, carrier sense and collision lines. It searches the nibble stream for the start-of-frame delimiter and then pairs the nibbles that follow into bytes. Each byte leaves with a first marker and a last marker.

The recovered receive clock may come up late, so part of the preamble may never be seen. The block therefore locks onto the delimiter after any number of preamble nibbles, as long as there is at least one. Every frame is closed on its last byte with three flags: receive error seen, odd nibble count (alignment) and collision seen. Carrier sense and collision are also passed on as registered status.

The last byte can only be identified once data valid falls, so each assembled byte is held back by one byte time. A frame that ends before it has a single whole byte produces no output.

Top module: `mii_rx_assembler`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every output is 0.
- R2: The block locks only when data valid is high on two consecutive nibbles, the first equal to 0x5 and the second equal to 0xD. One or more 0x5 nibbles before the 0xD are enough. A 0xD with no 0x5 directly before it gives no lock.
- R3: After lock, nibbles are paired into bytes with the first nibble of each pair in bits 3:0 and the second in bits 7:4.
- R4: Bytes come out in arrival order on `byte_valid`. `byte_first` is high only on the first byte of a frame and `byte_last` only on its final byte. A byte is presented one cycle after the edge that completes the next byte, or one cycle after the edge where data valid is seen low.
- R5: If receive error is high on the delimiter nibble or on any nibble after it while data valid is high, `frame_error` is 1 on that frame's last byte.
- R6: If data valid falls after an odd number of post-delimiter nibbles, the unpaired nibble is discarded and `frame_align` is 1 on the last byte.
- R7: If collision is high on the delimiter nibble or on any data nibble of a frame, `frame_collision` is 1 on that frame's last byte.
- R8: Nibbles before lock or with data valid low produce no bytes. Receive error outside a frame has no effect on the next frame. The three frame flags are 0 on every byte that is not a last byte.
- R9: `medium_busy` and `collision_now` show carrier sense and collision as sampled on the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 4 | Receive data nibble |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error |
| crs | input | 1 | Carrier sense |
| col | input | 1 | Collision detect |
| byte_data | output | 8 | Assembled byte |
| byte_valid | output | 1 | Byte strobe |
| byte_first | output | 1 | First byte of frame |
| byte_last | output | 1 | Last byte of frame |
| frame_error | output | 1 | Receive error seen in frame, valid on last byte |
| frame_align | output | 1 | Odd nibble count, valid on last byte |
| frame_collision | output | 1 | Collision seen in frame, valid on last byte |
| medium_busy | output | 1 | Registered carrier sense |
| collision_now | output | 1 | Registered collision |

## Verification
The bench builds the block with its default parameters: a 4-bit nibble, 0x5 as the preamble nibble and 0xD as the delimiter nibble. These settings exercise preamble lengths of fifteen, a few, a single nibble and zero. They also reach frames one byte long, frames with an odd nibble count, and frames with an error or a collision on one chosen nibble. Directed cases add a delimiter pattern with data valid low, receive error between frames, and the registered carrier and collision status.

// File: rtl/mii_rx_assembler.sv
module mii_rx_assembler #(
  parameter int          NIB_W   = 4,
  parameter logic [3:0]  PRE_NIB = 4'h5,
  parameter logic [3:0]  SFD_NIB = 4'hD
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NIB_W-1:0]     rxd,
  input  logic                 rx_dv,
  input  logic                 rx_er,
  input  logic                 crs,
  input  logic                 col,
  output logic [2*NIB_W-1:0]   byte_data,
  output logic                 byte_valid,
  output logic                 byte_first,
  output logic                 byte_last,
  output logic                 frame_error,
  output logic                 frame_align,
  output logic                 frame_collision,
  output logic                 medium_busy,
  output logic                 collision_now
);
  localparam int BYTE_W = 2 * NIB_W;

  logic              in_frame, prev_pre, have_lo;
  logic [NIB_W-1:0]  lo_nib;
  logic              pend_v, pend_first;
  logic [BYTE_W-1:0] pend_byte;
  logic              err_seen, col_seen;

  wire sfd_hit = rx_dv && prev_pre && (rxd == NIB_W'(SFD_NIB));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0; prev_pre <= 1'b0; have_lo <= 1'b0; lo_nib <= '0;
      pend_v <= 1'b0; pend_first <= 1'b0; pend_byte <= '0;
      err_seen <= 1'b0; col_seen <= 1'b0;
      byte_data <= '0; byte_valid <= 1'b0; byte_first <= 1'b0; byte_last <= 1'b0;
      frame_error <= 1'b0; frame_align <= 1'b0; frame_collision <= 1'b0;
      medium_busy <= 1'b0; collision_now <= 1'b0;
    end else begin
      medium_busy     <= crs;
      collision_now   <= col;
      byte_valid      <= 1'b0;
      byte_first      <= 1'b0;
      byte_last       <= 1'b0;
      frame_error     <= 1'b0;
      frame_align     <= 1'b0;
      frame_collision <= 1'b0;
      if (!in_frame) begin
        prev_pre <= rx_dv && (rxd == NIB_W'(PRE_NIB));
        if (sfd_hit) begin
          in_frame   <= 1'b1;
          have_lo    <= 1'b0;
          pend_v     <= 1'b0;
          pend_first <= 1'b1;
          err_seen   <= rx_er;
          col_seen   <= col;
        end
      end else if (rx_dv) begin
        err_seen <= err_seen | rx_er;
        col_seen <= col_seen | col;
        if (!have_lo) begin
          lo_nib  <= rxd;
          have_lo <= 1'b1;
        end else begin
          have_lo <= 1'b0;
          if (pend_v) begin
            byte_data  <= pend_byte;
            byte_valid <= 1'b1;
            byte_first <= pend_first;
            pend_first <= 1'b0;
          end
          pend_byte <= {rxd, lo_nib};
          pend_v    <= 1'b1;
        end
      end else begin
        in_frame <= 1'b0;
        prev_pre <= 1'b0;
        have_lo  <= 1'b0;
        pend_v   <= 1'b0;
        if (pend_v) begin
          byte_data       <= pend_byte;
          byte_valid      <= 1'b1;
          byte_first      <= pend_first;
          byte_last       <= 1'b1;
          frame_error     <= err_seen;
          frame_align     <= have_lo;
          frame_collision <= col_seen;
        end
      end
    end
  end

  AST_MARKS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_first || byte_last) |-> byte_valid); // R4
  AST_ERROR_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    frame_error |-> byte_last); // R5
  AST_ALIGN_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    frame_align |-> byte_last); // R6
  AST_COLLISION_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    frame_collision |-> byte_last); // R7
  AST_BYTE_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(in_frame)); // R8
  AST_BUSY_TRACKS_CRS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (medium_busy == $past(crs))); // R9
endmodule

// File: tb/mii_rx_assembler_test.sv
module mii_rx_assembler_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] rxd = '0;
  logic rx_dv = 0, rx_er = 0, crs = 0, col = 0;
  logic [7:0] byte_data;
  logic byte_valid, byte_first, byte_last, frame_error, frame_align, frame_collision;
  logic medium_busy, collision_now;

  mii_rx_assembler uut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er), .crs(crs), .col(col),
    .byte_data(byte_data), .byte_valid(byte_valid), .byte_first(byte_first), .byte_last(byte_last),
    .frame_error(frame_error), .frame_align(frame_align), .frame_collision(frame_collision),
    .medium_busy(medium_busy), .collision_now(collision_now));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] got_d [0:255];
  logic [4:0] got_f [0:255];
  logic [7:0] exp_d [0:255];
  logic [4:0] exp_f [0:255];
  int got_n = 0, exp_n = 0;

  // pre: number of 0x5 nibbles before 0xD; nb bytes; seed; odd; err nibble; col nibble
  localparam int TBL [0:6][0:5] = '{
    '{15, 6, 8'h12, 0, -1, -1},
    '{ 1, 3, 8'hA5, 0, -1, -1},
    '{ 3, 1, 8'h3C, 0, -1, -1},
    '{ 5, 4, 8'h40, 0,  3, -1},
    '{ 2, 5, 8'h77, 1, -1, -1},
    '{ 6, 3, 8'h09, 0, -1,  2},
    '{ 0, 3, 8'h5E, 0, -1, -1}
  };

  always @(negedge clk)
    if (byte_valid && got_n < 256) begin
      got_d[got_n] = byte_data;
      got_f[got_n] = {byte_first, byte_last, frame_error, frame_align, frame_collision};
      got_n++;
    end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic nib(input logic [3:0] d, input logic dv, input logic er, input logic c);
    @(negedge clk);
    rxd = d; rx_dv = dv; rx_er = er; col = c; crs = dv;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) nib(4'h0, 0, 0, 0);
  endtask

  task automatic frame(input int pre, input int nb, input int seed, input int odd,
                       input int errpos, input int colpos);
    logic [7:0] b;
    int k;
    got_n = 0; exp_n = 0;
    for (int i = 0; i < pre; i++) nib(4'h5, 1, 0, 0);
    nib(4'hD, 1, 0, 0);
    k = 0;
    for (int i = 0; i < nb; i++) begin
      b = 8'(seed + i * 37);
      nib(b[3:0], 1, k == errpos, k == colpos); k++;
      nib(b[7:4], 1, k == errpos, k == colpos); k++;
      if (pre > 0) begin
        exp_d[exp_n] = b;
        exp_f[exp_n] = {i == 0, i == nb - 1,
                        (i == nb - 1) && errpos >= 0, (i == nb - 1) && odd != 0,
                        (i == nb - 1) && colpos >= 0};
        exp_n++;
      end
    end
    if (odd != 0) nib(4'hF, 1, 0, 0);
    idle(3);
  endtask

  task automatic compare(input string req);
    chk(got_n == exp_n, {req, " byte count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(got_d[i] == exp_d[i], {req, " data R3"}, got_d[i], exp_d[i]);
      chk(got_f[i] == exp_f[i], {req, " markers/flags R4"}, got_f[i], exp_f[i]);
    end
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({byte_valid, byte_first, byte_last, frame_error, frame_align, frame_collision,
         medium_busy, collision_now, byte_data} == 0, "R1 in reset", byte_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk({byte_valid, byte_last, medium_busy, collision_now, byte_data} == 0,
        "R1 after reset", byte_data, 0);

    for (int v = 0; v < 7; v++) begin
      frame(TBL[v][0], TBL[v][1], TBL[v][2], TBL[v][3], TBL[v][4], TBL[v][5]);
      case (v)
        0: compare("R2 long preamble");
        1: compare("R2 single preamble nibble");
        2: compare("R4 one byte frame");
        3: compare("R5 receive error");
        4: compare("R6 odd nibbles");
        5: compare("R7 collision");
        default: compare("R2 no 0x5 before 0xD");
      endcase
    end

    // R8: delimiter pattern with data valid low, then error between frames
    got_n = 0;
    nib(4'h5, 0, 1, 0); nib(4'h5, 0, 0, 0); nib(4'hD, 0, 0, 0);
    nib(4'h3, 0, 0, 0); nib(4'h4, 0, 0, 0); idle(3);
    chk(got_n == 0, "R8 dv low no bytes", got_n, 0);
    nib(4'h9, 1, 1, 0); nib(4'h0, 0, 1, 0);
    frame(4, 2, 8'hC3, 0, -1, -1);
    compare("R8 error outside frame ignored");

    // R9: status follows carrier and collision one edge later
    @(negedge clk); crs = 1; col = 1;
    @(negedge clk);
    chk(medium_busy && collision_now, "R9 busy/col high", {medium_busy, collision_now}, 3);
    crs = 0; col = 0;
    @(negedge clk);
    chk(!medium_busy && !collision_now, "R9 busy/col low", {medium_busy, collision_now}, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule